// File: doc/BRIEF.md
# ADC Start-of-Conversion Trigger Synchronizer

This block gathers start-of-conversion requests that arise in the fast system-clock domain and hands them to the slower ADC-clock domain. There, each request opens a sample-and-hold window after a fixed delay. Three request sources exist: an event/timer line, a one-cycle software write strobe, and an external pin. The pin is first brought in through a synchronous input qualifier. Each source is edge-triggered. A detected rising edge is kept in a pending flag in the system domain until the ADC domain has captured it, and a four-phase request/acknowledge handshake then clears that flag.

In the ADC domain the captured request starts a fixed-latency sequence. The sequence ends in a one-cycle sample-and-hold start pulse, followed by a programmable sample window. A busy flag covers the whole sequence. If a request arrives while an earlier one is still uncaptured, the two are merged and a sticky overflow flag is raised. Software clears that flag with a write-1 strobe.

Top module: `adc_soc_sync`

## Requirements
- R1: A conversion is triggered by a low-to-high transition of `evt_trig`, `sw_trig` or the qualified `ext_pin`. A line that stays high produces exactly one conversion until it falls and rises again.
- R2: Rising edges on several sources that are registered in the same system-clock cycle form a single request. They give one `sh_start` pulse and do not set `ovf_flag`.
- R3: With `qual_sel` = 0, the pin passes only through a two-flop synchronizer, and its edge is registered on the 3rd system-clock edge after the pin is first sampled high. With `qual_sel` = N (1..7), the synchronized pin must hold a new value for N+1 consecutive system-clock samples, and its edge is registered on edge 4+N. A high pulse lasting only N system clocks triggers nothing.
- R4: When the ADC side is idle, `sh_start` is high for exactly one ADC cycle. It rises on the 5th ADC rising edge after the system-clock edge that registered the trigger: two synchronizer stages, one latch edge, then a fixed 2 ADC clocks.
- R5: `busy` rises on the ADC latch edge, which is the 3rd ADC edge after the trigger. It stays high for 2 + (`win_len`+1) ADC cycles, where `win_len` (0..15) sets a sample window of 1 to 16 ADC clocks that starts with `sh_start`.
- R6: A request that arrives while `busy` is high is held. It is latched on the 1st ADC edge after `busy` falls, and its `sh_start` rises on the 3rd ADC edge after `busy` falls.
- R7: A rising edge that arrives while an earlier request has not yet been captured by the ADC domain is merged into that request. It sets `ovf_flag`, which stays set, and only one `sh_start` results.
- R8: A one-cycle `ovf_clr` pulse clears `ovf_flag`. If a new overflow occurs in the same cycle, the set wins.
- R9: After reset, `sh_start`, `busy` and `ovf_flag` are low and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock, at least twice the ADC clock rate |
| adc_clk | input | 1 | ADC clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| evt_trig | input | 1 | Event/timer request line (system domain) |
| sw_trig | input | 1 | Software write strobe (system domain) |
| ext_pin | input | 1 | External trigger pin, asynchronous |
| qual_sel | input | 3 | Pin qualifier: 0 = synchronize only, N = N+1 equal samples |
| win_len | input | 4 | Sample window length minus one, in ADC clocks |
| ovf_clr | input | 1 | Write-1 strobe that clears the overflow flag |
| sh_start | output | 1 | One-ADC-cycle sample-and-hold start pulse |
| busy | output | 1 | High from ADC latch to end of the sample window |
| ovf_flag | output | 1 | Sticky merged-request flag (system domain) |

## Verification
Two events can land in the same system-clock cycle: a fresh rising edge and the overflow clear strobe. The bench times a software strobe to coincide with `ovf_clr` two cycles after an event edge, while the first request is still uncaptured, and then expects `ovf_flag` to read high. A second coincidence, rising edges on two sources in one cycle, is judged by counting exactly one `sh_start` pulse and by finding `ovf_flag` still low. A request that arrives during a long window is also provoked, and its start pulse is timed against the falling edge of `busy`.

// File: rtl/adc_soc_pkg.sv
package adc_soc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_DELAY  = 2'd1,
        PH_WINDOW = 2'd2
    } seq_phase_e;

    localparam int SRC_EVT = 0;
    localparam int SRC_SW  = 1;
    localparam int SRC_PIN = 2;
    localparam int NUM_SRC = 3;

endpackage

// File: rtl/soc_bit_sync.sv
module soc_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int SW = (STAGES < 2) ? 2 : STAGES;

    logic [SW-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[SW-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[SW-1];
endmodule

// File: rtl/soc_pin_qual.sv
module soc_pin_qual #(
    parameter int QW     = 3,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin,
    input  logic [QW-1:0] qual_sel,
    output logic          qual
);
    typedef struct packed {
        logic          level;
        logic [QW-1:0] cnt;
    } filt_t;

    logic  pin_s;
    filt_t st_d, st_q;

    soc_bit_sync #(.STAGES(STAGES)) u_pin_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin),
        .q     (pin_s)
    );

    // Count consecutive samples that disagree with the held level;
    // adopt the new level once qual_sel+1 of them have been seen.
    always_comb begin
        st_d = st_q;
        if (pin_s == st_q.level) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == qual_sel) begin
            st_d.level = pin_s;
            st_d.cnt   = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign qual = (qual_sel == '0) ? pin_s : st_q.level;
endmodule

// File: rtl/soc_req_hold.sv
module soc_req_hold #(
    parameter int NSRC   = 3,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src,
    input  logic            ack_in,
    input  logic            ovf_clr,
    output logic            req,
    output logic            ovf
);
    typedef struct packed {
        logic [NSRC-1:0] prev;
        logic            req;
        logic            hold;
        logic            ovf;
    } hold_t;

    logic            ack_s;
    logic [NSRC-1:0] rise_vec;
    logic            any_rise;
    hold_t           st_d, st_q;

    soc_bit_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_in),
        .q     (ack_s)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_edge
        assign rise_vec[i] = src[i] & ~st_q.prev[i];
    end

    assign any_rise = |rise_vec;

    always_comb begin
        st_d      = st_q;
        st_d.prev = src;

        // Deferred request moves to the live flag once the previous
        // handshake has fully returned to zero.
        if (st_q.hold && !ack_s) begin
            st_d.req  = 1'b1;
            st_d.hold = 1'b0;
        end

        // Captured by the ADC side: drop the live request.
        if (st_q.req && ack_s) begin
            st_d.req = 1'b0;
        end

        if (ovf_clr) begin
            st_d.ovf = 1'b0;
        end

        if (any_rise) begin
            if ((st_q.req && !ack_s) || st_q.hold) begin
                st_d.ovf = 1'b1;
            end else if (ack_s) begin
                st_d.hold = 1'b1;
            end else begin
                st_d.req = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req = st_q.req;
    assign ovf = st_q.ovf;
endmodule

// File: rtl/soc_adc_seq.sv
module soc_adc_seq
    import adc_soc_pkg::*;
#(
    parameter int WIN_W   = 4,
    parameter int LAT_CYC = 2,
    parameter int STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_in,
    input  logic [WIN_W-1:0] win_len,
    output logic             ack,
    output logic             sh_start,
    output logic             busy
);
    localparam int LW = (LAT_CYC > 1) ? $clog2(LAT_CYC) : 1;

    typedef struct packed {
        seq_phase_e       phase;
        logic [LW-1:0]    lat;
        logic [WIN_W-1:0] win;
        logic             ack;
        logic             sh;
    } seq_t;

    logic req_s;
    seq_t st_d, st_q;

    soc_bit_sync #(.STAGES(STAGES)) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_in),
        .q     (req_s)
    );

    always_comb begin
        st_d    = st_q;
        st_d.sh = 1'b0;

        if (!req_s) begin
            st_d.ack = 1'b0;
        end

        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_s && !st_q.ack) begin
                    st_d.ack   = 1'b1;
                    st_d.phase = PH_DELAY;
                    st_d.lat   = LW'(LAT_CYC - 1);
                end
            end
            PH_DELAY: begin
                if (st_q.lat == '0) begin
                    st_d.sh    = 1'b1;
                    st_d.phase = PH_WINDOW;
                    st_d.win   = win_len;
                end else begin
                    st_d.lat = st_q.lat - 1'b1;
                end
            end
            PH_WINDOW: begin
                if (st_q.win == '0) begin
                    st_d.phase = PH_IDLE;
                end else begin
                    st_d.win = st_q.win - 1'b1;
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE, lat: '0, win: '0, ack: 1'b0, sh: 1'b0};
        else        st_q <= st_d;
    end

    assign ack      = st_q.ack;
    assign sh_start = st_q.sh;
    assign busy     = (st_q.phase != PH_IDLE);
endmodule

// File: rtl/adc_soc_sync.sv
module adc_soc_sync
    import adc_soc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_W      = 3,
    parameter int WIN_W       = 4,
    parameter int LAT_CYC     = 2
) (
    input  logic              sys_clk,
    input  logic              adc_clk,
    input  logic              rst_n,
    input  logic              evt_trig,
    input  logic              sw_trig,
    input  logic              ext_pin,
    input  logic [QUAL_W-1:0] qual_sel,
    input  logic [WIN_W-1:0]  win_len,
    input  logic              ovf_clr,
    output logic              sh_start,
    output logic              busy,
    output logic              ovf_flag
);
    logic               pin_q;
    logic [NUM_SRC-1:0] src_vec;
    logic               req_x;
    logic               ack_x;

    soc_pin_qual #(.QW(QUAL_W), .STAGES(SYNC_STAGES)) u_qual (
        .clk      (sys_clk),
        .rst_n    (rst_n),
        .pin      (ext_pin),
        .qual_sel (qual_sel),
        .qual     (pin_q)
    );

    always_comb begin
        src_vec          = '0;
        src_vec[SRC_EVT] = evt_trig;
        src_vec[SRC_SW]  = sw_trig;
        src_vec[SRC_PIN] = pin_q;
    end

    soc_req_hold #(.NSRC(NUM_SRC), .STAGES(SYNC_STAGES)) u_hold (
        .clk     (sys_clk),
        .rst_n   (rst_n),
        .src     (src_vec),
        .ack_in  (ack_x),
        .ovf_clr (ovf_clr),
        .req     (req_x),
        .ovf     (ovf_flag)
    );

    soc_adc_seq #(.WIN_W(WIN_W), .LAT_CYC(LAT_CYC), .STAGES(SYNC_STAGES)) u_seq (
        .clk      (adc_clk),
        .rst_n    (rst_n),
        .req_in   (req_x),
        .win_len  (win_len),
        .ack      (ack_x),
        .sh_start (sh_start),
        .busy     (busy)
    );
endmodule

// File: rtl/soc_sync_checker.sv
module soc_sync_checker #(
    parameter int WIN_W   = 4,
    parameter int LAT_CYC = 2
) (
    input logic sys_clk,
    input logic adc_clk,
    input logic rst_n,
    input logic sh_start,
    input logic busy,
    input logic ovf_flag,
    input logic ovf_clr
);
    localparam int LIMIT = LAT_CYC + (1 << WIN_W);
    localparam int CW    = $clog2(LIMIT + 2) + 1;

    logic [CW-1:0] bcnt_q;

    // Number of busy cycles already completed in the current sequence.
    always_ff @(posedge adc_clk or negedge rst_n) begin
        if (!rst_n)    bcnt_q <= '0;
        else if (busy) bcnt_q <= bcnt_q + 1'b1;
        else           bcnt_q <= '0;
    end

    p_sh_one_cycle_r4: assert property (@(posedge adc_clk) disable iff (!rst_n)
        sh_start |=> !sh_start);

    p_sh_latency_r4: assert property (@(posedge adc_clk) disable iff (!rst_n)
        sh_start |-> (bcnt_q == CW'(LAT_CYC)));

    p_sh_in_busy_r5: assert property (@(posedge adc_clk) disable iff (!rst_n)
        sh_start |-> busy);

    p_busy_bound_r5: assert property (@(posedge adc_clk) disable iff (!rst_n)
        busy |-> (bcnt_q < CW'(LIMIT)));

    p_ovf_clear_only_r8: assert property (@(posedge sys_clk) disable iff (!rst_n)
        $fell(ovf_flag) |-> $past(ovf_clr));
endmodule

bind adc_soc_sync soc_sync_checker #(.WIN_W(WIN_W), .LAT_CYC(LAT_CYC)) u_chk (
    .sys_clk  (sys_clk),
    .adc_clk  (adc_clk),
    .rst_n    (rst_n),
    .sh_start (sh_start),
    .busy     (busy),
    .ovf_flag (ovf_flag),
    .ovf_clr  (ovf_clr)
);

// File: tb/adc_soc_sync_bench.sv
module adc_soc_sync_bench;
    logic       sys_clk = 1'b0;
    logic       adc_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic       evt_trig = 1'b0, sw_trig = 1'b0, ext_pin = 1'b0, ovf_clr = 1'b0;
    logic [2:0] qual_sel = '0;
    logic [3:0] win_len  = '0;
    logic       sh_start, busy, ovf_flag;

    int checks = 0, fails = 0, adc_edges = 0, sh_total = 0;
    bit done = 1'b0;

    adc_soc_sync u_adc_soc_sync (
        .sys_clk(sys_clk), .adc_clk(adc_clk), .rst_n(rst_n),
        .evt_trig(evt_trig), .sw_trig(sw_trig), .ext_pin(ext_pin),
        .qual_sel(qual_sel), .win_len(win_len), .ovf_clr(ovf_clr),
        .sh_start(sh_start), .busy(busy), .ovf_flag(ovf_flag)
    );

    always #4 sys_clk = ~sys_clk;
    initial begin
        #2;
        forever #16 adc_clk = ~adc_clk;
    end

    always @(posedge adc_clk) adc_edges++;
    always @(negedge adc_clk) if (sh_start) sh_total++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Follow one conversion from the registered trigger; checks R4 and R5.
    task automatic measure(input int e0, input int w);
        int first_b = -1;
        int sh_at = -1;
        int nb = 0;
        int nsh = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge adc_clk);
            if (busy) begin
                nb++;
                if (first_b < 0) first_b = adc_edges - e0;
            end
            if (sh_start) begin
                nsh++;
                if (sh_at < 0) sh_at = adc_edges - e0;
            end
            if (first_b >= 0 && !busy) break;
        end
        check(sh_at == 5, "R4 latency", sh_at, 5);
        check(nsh == 1, "R4 pulse width", nsh, 1);
        check(first_b == 3, "R5 busy rise", first_b, 3);
        check(nb == w + 3, "R5 busy length", nb, w + 3);
        repeat (6) @(negedge adc_clk);
    endtask

    task automatic pulse_line(input int which, input int hold_cyc, output int e0);
        @(negedge sys_clk);
        if (which == 0) evt_trig = 1'b1; else sw_trig = 1'b1;
        @(posedge sys_clk);
        #1 e0 = adc_edges;
        fork
            begin
                repeat (hold_cyc) @(negedge sys_clk);
                evt_trig = 1'b0;
                sw_trig  = 1'b0;
            end
        join_none
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
        end
    end

    initial begin
        int e0;
        int base;
        int fall_e;
        int sh_at;
        repeat (5) @(negedge sys_clk);
        rst_n = 1'b1;
        @(negedge sys_clk);
        // R9: reset state
        check(sh_start == 1'b0, "R9 sh_start", sh_start, 0);
        check(busy == 1'b0, "R9 busy", busy, 0);
        check(ovf_flag == 1'b0, "R9 ovf_flag", ovf_flag, 0);

        // R1/R4/R5 sweep: event and software sources across every window length
        for (int s = 0; s < 2; s++) begin
            for (int w = 0; w < 16; w++) begin
                win_len = 4'(w);
                pulse_line(s, (s == 0) ? 8 : 1, e0);
                measure(e0, w);
            end
        end

        // R3: pin qualifier, every sample count, measured end to end
        for (int n = 0; n < 8; n++) begin
            qual_sel = 3'(n);
            win_len  = 4'(n);
            @(negedge sys_clk);
            ext_pin = 1'b1;
            repeat ((n == 0) ? 3 : 4 + n) @(posedge sys_clk);
            #1 e0 = adc_edges;
            fork
                begin
                    repeat (6) @(negedge sys_clk);
                    ext_pin = 1'b0;
                end
            join_none
            measure(e0, n);
        end

        // R3: pulses one sample short are rejected
        for (int n = 1; n < 8; n++) begin
            qual_sel = 3'(n);
            base = sh_total;
            @(negedge sys_clk);
            ext_pin = 1'b1;
            repeat (n) @(negedge sys_clk);
            ext_pin = 1'b0;
            repeat (12) @(negedge adc_clk);
            check(sh_total == base, "R3 short pin pulse ignored", sh_total - base, 0);
        end
        qual_sel = '0;

        // R1: line held high gives one conversion only
        win_len = 4'd0;
        base = sh_total;
        @(negedge sys_clk);
        evt_trig = 1'b1;
        repeat (300) @(negedge sys_clk);
        check(sh_total - base == 1, "R1 held line", sh_total - base, 1);
        evt_trig = 1'b0;
        repeat (6) @(negedge adc_clk);

        // R2: coincident edges on two sources
        base = sh_total;
        @(negedge sys_clk);
        evt_trig = 1'b1;
        sw_trig  = 1'b1;
        @(negedge sys_clk);
        sw_trig = 1'b0;
        repeat (4) @(negedge sys_clk);
        evt_trig = 1'b0;
        repeat (20) @(negedge adc_clk);
        check(sh_total - base == 1, "R2 coincident edges", sh_total - base, 1);
        check(ovf_flag == 1'b0, "R2 no overflow", ovf_flag, 0);

        // R7: second edge before capture merges and sets overflow
        base = sh_total;
        @(negedge sys_clk);
        evt_trig = 1'b1;
        repeat (2) @(negedge sys_clk);
        sw_trig = 1'b1;
        @(negedge sys_clk);
        sw_trig = 1'b0;
        evt_trig = 1'b0;
        repeat (20) @(negedge adc_clk);
        @(negedge sys_clk);
        check(sh_total - base == 1, "R7 merged request", sh_total - base, 1);
        check(ovf_flag == 1'b1, "R7 overflow set", ovf_flag, 1);

        // R8: clear, then clear colliding with a new overflow
        ovf_clr = 1'b1;
        @(negedge sys_clk);
        ovf_clr = 1'b0;
        @(negedge sys_clk);
        check(ovf_flag == 1'b0, "R8 clear", ovf_flag, 0);
        evt_trig = 1'b1;
        repeat (2) @(negedge sys_clk);
        sw_trig = 1'b1;
        ovf_clr = 1'b1;
        @(negedge sys_clk);
        sw_trig = 1'b0;
        ovf_clr = 1'b0;
        evt_trig = 1'b0;
        check(ovf_flag == 1'b1, "R8 set wins over clear", ovf_flag, 1);
        repeat (20) @(negedge adc_clk);
        ovf_clr = 1'b1;
        @(negedge sys_clk);
        ovf_clr = 1'b0;
        @(negedge sys_clk);
        check(ovf_flag == 1'b0, "R8 clear again", ovf_flag, 0);

        // R6: request arriving during a long window is held
        win_len = 4'd15;
        pulse_line(0, 8, e0);
        while (!sh_start) @(negedge adc_clk);
        repeat (4) @(negedge adc_clk);
        @(negedge sys_clk);
        sw_trig = 1'b1;
        @(negedge sys_clk);
        sw_trig = 1'b0;
        while (busy) @(negedge adc_clk);
        fall_e = adc_edges;
        sh_at = -1;
        for (int i = 0; i < 20; i++) begin
            @(negedge adc_clk);
            if (sh_start && sh_at < 0) sh_at = adc_edges - fall_e;
        end
        check(sh_at == 3, "R6 held request start", sh_at, 3);
        repeat (30) @(negedge adc_clk);
        @(negedge sys_clk);
        check(ovf_flag == 1'b0, "R6 no overflow", ovf_flag, 0);
        check(busy == 1'b0, "R6 idle afterwards", busy, 0);

        done = 1'b1;
        summary();
    end
endmodule